// File: doc/BRIEF.md
# SAR ADC Sequencer with Power-Up Delay

This block controls a multiplexed successive-approximation analog-to-digital converter from a 32-bit memory-mapped register bus. Software selects an input channel and sets the power bit in the control register. That single write powers the converter and starts one conversion. The block then waits a programmable number of converter clock periods so the analog front end can settle. After the wait it resolves the result one bit per converter clock, from the most significant bit down. It stores the right-aligned code and raises a done flag, which drives the interrupt output when the interrupt is enabled.

The analog side is reduced to two signals. A trial-code output feeds the DAC. A comparator input reports whether the sampled input is at or above that trial code. Converter clock periods arrive as a single-cycle enable, `conv_tick`, in the bus clock domain. Writing the control register with the power bit clear powers the converter down, aborts any conversion and clears the done flag.

Top module: `sar_adc_seq`

## Requirements
- R1: The register map is fixed by byte address. 0x00 holds the result, 0x04 the status, 0x08 the control and 0x0c the power-up delay. Writes to 0x00 and 0x04 change nothing.
- R2: Status bit 0 is the busy flag. It reads 1 from the cycle after a starting control write until the conversion completes or is aborted.
- R3: The control register has these fields. Bits 2:0 select the channel, driven on `adc_chan`. Bit 3 is power, driven on `adc_pwr`. Bit 5 enables the interrupt. Bit 6 is the read-only done flag. All other bits read 0. Busy implies power on.
- R4: A control write with bit 3 set while not busy has four effects: it starts a conversion on the written channel, sets power, clears the done flag and sets busy.
- R5: The delay register keeps only its low 6 bits, and bits 31:6 read 0.
- R6: With delay value D and resolution W, a conversion consumes exactly D+1+W cycles with `conv_tick` high. Cycles with `conv_tick` low do not advance it.
- R7: Trial bits are decided MSB first, one per tick. A bit is kept when `cmp_in` is 1 while that trial code is presented. The result is therefore the input value, clipped to 2^W-1.
- R8: The result register is right-aligned, with bits above W reading 0. It holds its value until the next conversion completes.
- R9: The done flag is set when a conversion completes. `irq` equals interrupt enable AND done flag, and is never high while busy.
- R10: A control write with bit 3 clear has four effects: it drops power, ends busy, clears the done flag and therefore `irq`. It leaves the result register unchanged.
- R11: A control write with bit 3 set while busy is ignored. The channel, the enable and the running conversion are unaffected, and no new conversion follows.
- R12: After reset, result, status and control read 0, the delay reads 8, and `irq` and `adc_pwr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| conv_tick | input | 1 | One-cycle enable marking a converter clock period |
| cmp_in | input | 1 | Comparator: input at or above trial code |
| adc_pwr | output | 1 | Converter power enable |
| adc_chan | output | CH_W | Selected analog input channel |
| trial_code | output | RES_W | Code presented to the DAC |
| irq | output | 1 | End-of-conversion interrupt |

## Verification
The bench builds the block with its default 10-bit resolution, 3-bit channel field and reset delay of 8. This puts full-scale clipping within reach: random inputs up to 4095 exercise values above 1023. With 6 delay bits, random delays cover the whole 0 to 63 range. This includes a delay of 0, where approximation begins on the first tick after the start. A random tick-enable pattern shows that only enabled cycles advance the delay count and the bit decisions.

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int RES_W   = 10,
  parameter int CH_W    = 3,
  parameter int DLY_W   = 6,
  parameter int DLY_RST = 8,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              conv_tick,
  input  logic              cmp_in,
  output logic              adc_pwr,
  output logic [CH_W-1:0]   adc_chan,
  output logic [RES_W-1:0]  trial_code,
  output logic              irq
);
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_DLY  = ADDR_W'(12);
  localparam logic [RES_W-1:0]  MSB1   = RES_W'(1) << (RES_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CONV} st_t;

  st_t              st;
  logic [DLY_W-1:0] dly_q, cnt;
  logic [RES_W-1:0] code, result, bitm, keep, code_nx;
  logic [IDX_W-1:0] idx;
  logic             pwr, ien, flag, busy;
  logic [CH_W-1:0]  chan;
  logic             wr_ctrl;

  assign busy       = (st != S_IDLE);
  assign wr_ctrl    = bus_wr && (bus_addr == A_CTRL);
  assign adc_pwr    = pwr;
  assign adc_chan   = chan;
  assign trial_code = code;
  assign irq        = ien & flag;

  assign bitm    = RES_W'(1) << idx;
  assign keep    = cmp_in ? code : (code & ~bitm);
  assign code_nx = (idx == '0) ? keep : (keep | (bitm >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dly_q  <= DLY_W'(DLY_RST);
      cnt    <= '0;
      code   <= '0;
      result <= '0;
      idx    <= '0;
      pwr    <= 1'b0;
      ien    <= 1'b0;
      flag   <= 1'b0;
      chan   <= '0;
    end else begin
      if (bus_wr && bus_addr == A_DLY) dly_q <= bus_wdata[DLY_W-1:0];
      if (wr_ctrl && !bus_wdata[3]) begin
        pwr  <= 1'b0;
        flag <= 1'b0;
        st   <= S_IDLE;
        chan <= bus_wdata[CH_W-1:0];
        ien  <= bus_wdata[5];
      end else if (wr_ctrl && !busy) begin
        pwr  <= 1'b1;
        flag <= 1'b0;
        chan <= bus_wdata[CH_W-1:0];
        ien  <= bus_wdata[5];
        cnt  <= dly_q;
        st   <= S_WAIT;
      end else if (conv_tick) begin
        case (st)
          S_WAIT: begin
            if (cnt == '0) begin
              st   <= S_CONV;
              code <= MSB1;
              idx  <= IDX_W'(RES_W - 1);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          S_CONV: begin
            code <= code_nx;
            if (idx == '0) begin
              result <= code_nx;
              flag   <= 1'b1;
              st     <= S_IDLE;
            end else begin
              idx <= idx - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic [31:0] ctrl_rd;
  always_comb begin
    ctrl_rd              = '0;
    ctrl_rd[CH_W-1:0]    = chan;
    ctrl_rd[3]           = pwr;
    ctrl_rd[5]           = ien;
    ctrl_rd[6]           = flag;
  end

  always_comb begin
    case (bus_addr)
      A_RES:   bus_rdata = 32'(result);
      A_STAT:  bus_rdata = {31'd0, busy};
      A_CTRL:  bus_rdata = ctrl_rd;
      A_DLY:   bus_rdata = 32'(dly_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int RES_W  = 10,
  parameter int CH_W   = 3,
  parameter int DLY_W  = 6,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              adc_pwr,
  input logic [CH_W-1:0]   adc_chan,
  input logic              irq,
  input logic              busy
);
  logic ctrl_wr;
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(8));

  p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  p_busy_pwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> adc_pwr);

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[3] && !busy) |=> (busy && adc_pwr && !irq));

  p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[3]) |=> (!busy && !adc_pwr && !irq));

  p_hold_chan_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(adc_chan));

  p_res_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(0)) |-> (bus_rdata[31:RES_W] == '0));

  p_dly_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(12)) |-> (bus_rdata[31:DLY_W] == '0));
endmodule

bind sar_adc_seq sar_adc_seq_chk #(
  .RES_W(RES_W), .CH_W(CH_W), .DLY_W(DLY_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_pwr(adc_pwr),
  .adc_chan(adc_chan), .irq(irq), .busy(busy)
);

// File: tb/sar_adc_seq_tb_top.sv
`timescale 1ns/1ps
module sar_adc_seq_tb_top;
  localparam int RES_W = 10;
  localparam int CH_W  = 3;
  localparam int MAXC  = (1 << RES_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [3:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              conv_tick = 1'b1;
  logic              cmp_in;
  logic              adc_pwr;
  logic [CH_W-1:0]   adc_chan;
  logic [RES_W-1:0]  trial_code;
  logic              irq;
  logic [15:0]       vin [8];

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign cmp_in = (32'(vin[adc_chan]) >= 32'(trial_code));

  sar_adc_seq #(.RES_W(RES_W), .CH_W(CH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_tick(conv_tick),
    .cmp_in(cmp_in), .adc_pwr(adc_pwr), .adc_chan(adc_chan),
    .trial_code(trial_code), .irq(irq)
  );

  function automatic logic [31:0] exp_code(input int v);
    return (v > MAXC) ? 32'(MAXC) : 32'(v);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run_conv(input int ch, input int d, input bit ien, input bit rnd);
    int cnt = 0;
    bit pb, pt;
    logic [31:0] r;
    bus_write(4'hc, 32'(d));
    bus_write(4'h8, 32'((int'(ien) << 5) | 8 | ch));
    bus_addr = 4'h4;
    conv_tick = rnd ? 1'($urandom % 2) : 1'b1;
    #1 chk("R2 busy after start", bus_rdata, 32'd1);
    pb = 1'b1; pt = conv_tick;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (pb && pt) cnt++;
      if (!bus_rdata[0]) break;
      conv_tick = rnd ? 1'($urandom % 2) : 1'b1;
      pb = 1'b1; pt = conv_tick;
    end
    conv_tick = 1'b1;
    chk("R6 tick count", 32'(cnt), 32'(d + 1 + RES_W));
    bus_read(4'h0, r);
    chk("R7 result", r, exp_code(int'(vin[ch])));
    chk("R9 irq", {31'd0, irq}, {31'd0, ien});
    bus_read(4'h8, r);
    chk("R3 ctrl readback", r, 32'((1 << 6) | (int'(ien) << 5) | 8 | ch));
    chk("R3 adc_chan", 32'(adc_chan), 32'(ch));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] r, held;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 8; i++) vin[i] = 16'(i * 100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    bus_read(4'h0, r); chk("R12 result reset", r, 0);
    bus_read(4'h4, r); chk("R12 status reset", r, 0);
    bus_read(4'h8, r); chk("R12 ctrl reset", r, 0);
    bus_read(4'hc, r); chk("R12 delay reset", r, 8);
    chk("R12 irq/pwr reset", {30'd0, irq, adc_pwr}, 0);

    bus_write(4'hc, 32'hffff_ffff);
    bus_read(4'hc, r); chk("R5 delay width", r, 32'h3f);

    vin[2] = 16'd512;  run_conv(2, 8, 1'b1, 1'b0);
    vin[0] = 16'd0;    run_conv(0, 0, 1'b0, 1'b0);
    vin[7] = 16'd1023; run_conv(7, 63, 1'b1, 1'b1);
    vin[5] = 16'd5000; run_conv(5, 3, 1'b1, 1'b0);
    bus_read(4'h0, r); chk("R8 upper bits zero", r & ~32'(MAXC), 0);

    bus_write(4'h0, 32'h0000_0abc);
    bus_write(4'h4, 32'h0000_0001);
    bus_read(4'h0, r); chk("R1 result write ignored", r, 32'd1023);
    bus_read(4'h4, r); chk("R1 status write ignored", r, 0);

    bus_write(4'h8, 32'h0000_0020);
    chk("R10 irq cleared", {31'd0, irq}, 0);
    bus_read(4'h8, r); chk("R10 ctrl after off", r, 32'h20);

    vin[1] = 16'd300; vin[6] = 16'd900;
    bus_write(4'hc, 32'd8);
    bus_write(4'h8, 32'h0000_0029);
    repeat (3) @(negedge clk);
    bus_write(4'h8, 32'h0000_000e);
    bus_read(4'h8, r); chk("R11 ctrl unchanged", r, 32'h29);
    repeat (30) @(negedge clk);
    bus_read(4'h0, r); chk("R11 result from first channel", r, 32'd300);
    bus_read(4'h4, r); chk("R11 no restart", r, 0);
    chk("R9 irq after done", {31'd0, irq}, 1);

    bus_read(4'h0, held);
    bus_write(4'h8, 32'h0000_000a);
    repeat (4) @(negedge clk);
    bus_write(4'h8, 32'h0000_0000);
    bus_read(4'h4, r); chk("R10 abort busy", r, 0);
    chk("R10 abort pwr/irq", {30'd0, adc_pwr, irq}, 0);
    repeat (30) @(negedge clk);
    bus_read(4'h0, r); chk("R8 R10 result held", r, held);

    for (int k = 0; k < 20; k++) begin
      int ch, d;
      bit ien, rnd;
      ch = int'($urandom % 8);
      d = int'($urandom % 64);
      ien = 1'($urandom % 2);
      rnd = 1'($urandom % 2);
      vin[ch] = 16'($urandom % 4096);
      run_conv(ch, d, ien, rnd);
    end

    finish_run();
  end
endmodule